// File: doc/BRIEF.md
# Segment Descriptor Cache Loader

This block turns a raw 64-bit segment descriptor into the hidden state that sits behind a segment register: a base address, a byte-granular limit and a compact attribute word. A load strobe presents the descriptor together with the selector that named it. The block splits the descriptor into its fields, chooses the attribute bits by descriptor class (code, data or system) and commits base, limit and attributes in one clock. A selector whose index and table bit are both zero is a null load, and it leaves the cache as it was.

A second strobe, the upper-half operation, serves the 16-byte system descriptors of long mode. It combines a 32-bit extension word with the low descriptor word into a 64-bit result. The low 32 bits come from one of two field layouts, picked by descriptor type: the base layout for table and task-state descriptors, and the offset layout for gates. Descriptor kinds the block cannot accept raise an error flag, and the registered state stays untouched. Memory fetch and privilege checks are done outside the block.

A small state machine records the outcome of the most recent strobe: ST_IDLE after reset, ST_CACHED after an accepted load, ST_SKIPPED after a null load, ST_UPPER after an accepted upper-half operation, and ST_FAULT after any rejected strobe. A strobe moves the machine from any state straight to the state for its outcome. With no strobe the machine stays where it is.

Top module: `seg_cache_loader`

## Requirements
- R1: While reset is low and in the cycle after it, base, limit, attributes and upper result read zero and the error flag is low.
- R2: A load whose selector has bits 15:2 all zero leaves base, limit and attributes unchanged and clears the error flag, whatever the descriptor and the selector bits 1:0 hold.
- R3: An accepted load sets base to descriptor bits 63:56 above bits 39:16, zero-extended. The raw limit is bits 51:48 above bits 15:0. When granularity bit 55 is set, the limit becomes the raw limit shifted left by 12 with the low 12 bits filled with ones.
- R4: The attribute word holds DPL (descriptor bits 46:45) in bits 1:0 and the default-size bit D (bit 54) in bit 2, for every accepted load. Bit 3 is long-mode, bit 4 readable, bit 5 writable and bit 6 expand-down.
- R5: A code descriptor (bit 44 set, type bit 3 set, type in bits 43:40) takes readable from type bit 1 and long-mode from bit 53, with writable and expand-down clear.
- R6: A data descriptor (bit 44 set, type bit 3 clear) takes expand-down from type bit 2 and writable from type bit 1, sets readable, and clears long-mode.
- R7: A system descriptor (bit 44 clear) gets readable and writable set. If its type bit 2 is set it is a gate: the load is rejected, the error flag rises and the cache is kept.
- R8: A code or data descriptor with the present bit 47 clear is rejected: the error flag rises and the cache is kept.
- R9: An upper-half operation puts the extension word into result bits 63:32. Types 0x2, 0x9 and 0xB put descriptor bits 39:16 into result 23:0 and bits 63:56 into result 31:24. Types 0xC, 0xE and 0xF put descriptor bits 15:0 into result 15:0 and bits 63:48 into result 31:16. Any other type is rejected: the error flag rises and the result is kept.
- R10: A strobe takes effect in the cycle after the clock edge that samples it. The error flag holds its value until the next strobe. When both strobes are high together, the load is performed and the upper-half operation is dropped.
- R11: An upper-half operation never changes base, limit or attributes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Load strobe for the descriptor cache |
| upper_i | input | 1 | Upper-half operation strobe |
| desc_i | input | 64 | Raw descriptor |
| sel_i | input | 16 | Selector used for the load |
| hi_word_i | input | HI_W (32) | Extension word of a 16-byte descriptor |
| base_o | output | BASE_W (64) | Cached segment base |
| limit_o | output | 32 | Cached byte-granular limit |
| attr_o | output | 7 | Cached attribute word |
| upper_o | output | HI_W+32 (64) | Upper-half result |
| err_o | output | 1 | Last strobe was rejected |

## Verification
The properties assume that both strobes are low during reset and that inputs change only between clock edges. Under that assumption each strobe is a single sampled event, and the outcome can be seen on the registered outputs one cycle later. The directed stimulus drives every input on the falling edge and holds each strobe high for exactly one rising edge. Null, faulting and upper-half strobes are spaced so that the cache value they must preserve has been settled by an earlier accepted load.

// File: rtl/seg_ldr_pkg.sv
package seg_ldr_pkg;

    localparam int DESC_W     = 64;
    localparam int GRAN_SHIFT = 12;

    // Raw descriptor, most significant field first
    typedef struct packed {
        logic [7:0]  base_hi;
        logic        gran;
        logic        dsz;
        logic        lng;
        logic        avl;
        logic [3:0]  lim_hi;
        logic        present;
        logic [1:0]  dpl;
        logic        s;
        logic [3:0]  typ;
        logic [23:0] base_lo;
        logic [15:0] lim_lo;
    } desc_t;

    // Attribute word: dpl in [1:0] up to expand_down in [6]
    typedef struct packed {
        logic       expand_down;
        logic       writable;
        logic       readable;
        logic       long_mode;
        logic       dflt_size;
        logic [1:0] dpl;
    } attr_t;

    localparam int ATTR_W = $bits(attr_t);

    // System types accepted by the upper-half operation
    localparam logic [3:0] TY_LDT       = 4'h2;
    localparam logic [3:0] TY_TSS_AVAIL = 4'h9;
    localparam logic [3:0] TY_TSS_BUSY  = 4'hB;
    localparam logic [3:0] TY_CALL_GATE = 4'hC;
    localparam logic [3:0] TY_INTR_GATE = 4'hE;
    localparam logic [3:0] TY_TRAP_GATE = 4'hF;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CACHED  = 3'd1,
        ST_SKIPPED = 3'd2,
        ST_UPPER   = 3'd3,
        ST_FAULT   = 3'd4
    } ldr_state_e;

endpackage

// File: rtl/seg_desc_decode.sv
module seg_desc_decode
    import seg_ldr_pkg::*;
(
    input  desc_t       desc,
    output logic [31:0] base,
    output logic [31:0] limit,
    output attr_t       attr,
    output logic        bad
);

    localparam int RAW_LIM_W = 20;

    logic [RAW_LIM_W-1:0] raw_limit;

    assign raw_limit = {desc.lim_hi, desc.lim_lo};
    assign base      = {desc.base_hi, desc.base_lo};

    always_comb begin
        if (desc.gran)
            limit = {raw_limit, {GRAN_SHIFT{1'b1}}};
        else
            limit = {{(32-RAW_LIM_W){1'b0}}, raw_limit};
    end

    always_comb begin
        attr           = '0;
        attr.dpl       = desc.dpl;
        attr.dflt_size = desc.dsz;
        bad            = 1'b0;
        if (!desc.s) begin
            // system class: type bit 2 marks a gate
            bad           = desc.typ[2];
            attr.readable = 1'b1;
            attr.writable = 1'b1;
        end else begin
            bad = !desc.present;
            if (desc.typ[3]) begin
                attr.readable  = desc.typ[1];
                attr.long_mode = desc.lng;
            end else begin
                attr.expand_down = desc.typ[2];
                attr.readable    = 1'b1;
                attr.writable    = desc.typ[1];
            end
        end
    end

endmodule

// File: rtl/seg_desc_upper.sv
module seg_desc_upper
    import seg_ldr_pkg::*;
#(
    parameter int HI_W = 32
) (
    input  desc_t            desc,
    input  logic [HI_W-1:0]  hi_word,
    output logic [HI_W+31:0] result,
    output logic             bad
);

    logic [DESC_W-1:0] raw;
    logic [31:0]       low_part;

    assign raw = desc;

    always_comb begin
        low_part = '0;
        bad      = 1'b0;
        unique case (desc.typ)
            TY_LDT, TY_TSS_AVAIL, TY_TSS_BUSY:
                low_part = {desc.base_hi, desc.base_lo};
            TY_CALL_GATE, TY_INTR_GATE, TY_TRAP_GATE:
                low_part = {raw[63:48], raw[15:0]};
            default:
                bad = 1'b1;
        endcase
    end

    assign result = {hi_word, low_part};

endmodule

// File: rtl/seg_cache_loader.sv
module seg_cache_loader
    import seg_ldr_pkg::*;
#(
    parameter int BASE_W = 64,
    parameter int HI_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              upper_i,
    input  logic [63:0]       desc_i,
    input  logic [15:0]       sel_i,
    input  logic [HI_W-1:0]   hi_word_i,
    output logic [BASE_W-1:0] base_o,
    output logic [31:0]       limit_o,
    output logic [6:0]        attr_o,
    output logic [HI_W+31:0]  upper_o,
    output logic              err_o
);

    localparam int UP_W = HI_W + 32;

    desc_t       desc;
    logic [31:0] dec_base;
    logic [31:0] dec_limit;
    attr_t       dec_attr;
    logic        dec_bad;
    logic [UP_W-1:0] up_result;
    logic        up_bad;
    logic        sel_null;
    logic        strobe;

    ldr_state_e  state_q;
    ldr_state_e  state_d;

    assign desc     = desc_t'(desc_i);
    assign sel_null = (sel_i[15:2] == '0);
    assign strobe   = load_i | upper_i;

    seg_desc_decode u_decode (
        .desc  (desc),
        .base  (dec_base),
        .limit (dec_limit),
        .attr  (dec_attr),
        .bad   (dec_bad)
    );

    seg_desc_upper #(.HI_W(HI_W)) u_upper (
        .desc    (desc),
        .hi_word (hi_word_i),
        .result  (up_result),
        .bad     (up_bad)
    );

    // outcome of the current strobe; load wins over upper
    always_comb begin
        state_d = state_q;
        if (load_i) begin
            if (sel_null)
                state_d = ST_SKIPPED;
            else if (dec_bad)
                state_d = ST_FAULT;
            else
                state_d = ST_CACHED;
        end else if (upper_i) begin
            state_d = up_bad ? ST_FAULT : ST_UPPER;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_o  <= '0;
            limit_o <= '0;
            attr_o  <= '0;
            upper_o <= '0;
        end else if (strobe) begin
            unique case (state_d)
                ST_CACHED: begin
                    base_o  <= BASE_W'(dec_base);
                    limit_o <= dec_limit;
                    attr_o  <= dec_attr;
                end
                ST_UPPER:   upper_o <= up_result;
                ST_IDLE, ST_SKIPPED, ST_FAULT: ;
                default: ;
            endcase
        end
    end

    assign err_o = (state_q == ST_FAULT);

endmodule

// File: rtl/seg_cache_loader_chk.sv
module seg_cache_loader_chk #(
    parameter int BASE_W = 64,
    parameter int HI_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_i,
    input logic              upper_i,
    input logic [63:0]       desc_i,
    input logic [15:0]       sel_i,
    input logic [HI_W-1:0]   hi_word_i,
    input logic [BASE_W-1:0] base_o,
    input logic [31:0]       limit_o,
    input logic [6:0]        attr_o,
    input logic [HI_W+31:0]  upper_o,
    input logic              err_o
);

    logic null_sel;
    assign null_sel = (sel_i[15:2] == 14'd0);

    AST_NULL_KEEPS_CACHE: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && null_sel |=> $stable(base_o) && $stable(limit_o) && $stable(attr_o) && !err_o); // R2

    AST_GRAN_FILLS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && !null_sel && desc_i[55] |=> err_o || limit_o[11:0] == 12'hFFF); // R3

    AST_DPL_COPIED: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && !null_sel |=> err_o || attr_o[1:0] == $past(desc_i[46:45])); // R4

    AST_FAULT_KEEPS_CACHE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $stable(base_o) && $stable(limit_o) && $stable(attr_o)); // R8

    AST_UPPER_HIGH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        upper_i && !load_i |=> err_o || upper_o[HI_W+31:32] == $past(hi_word_i)); // R9

    AST_ERR_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i || upper_i) |=> $stable(err_o)); // R10

    AST_UPPER_LEAVES_CACHE: assert property (@(posedge clk) disable iff (!rst_n)
        upper_i && !load_i |=> $stable(base_o) && $stable(limit_o) && $stable(attr_o)); // R11

endmodule

bind seg_cache_loader seg_cache_loader_chk #(.BASE_W(BASE_W), .HI_W(HI_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_i),
    .upper_i   (upper_i),
    .desc_i    (desc_i),
    .sel_i     (sel_i),
    .hi_word_i (hi_word_i),
    .base_o    (base_o),
    .limit_o   (limit_o),
    .attr_o    (attr_o),
    .upper_o   (upper_o),
    .err_o     (err_o)
);

// File: tb/seg_cache_loader_test.sv
module seg_cache_loader_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic        upper_i = 1'b0;
    logic [63:0] desc_i = '0;
    logic [15:0] sel_i = '0;
    logic [31:0] hi_word_i = '0;
    logic [63:0] base_o;
    logic [31:0] limit_o;
    logic [6:0]  attr_o;
    logic [63:0] upper_o;
    logic        err_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [63:0] e_base  = '0;
    logic [31:0] e_limit = '0;
    logic [6:0]  e_attr  = '0;
    logic [63:0] e_upper = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_cache_loader uut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .upper_i(upper_i),
        .desc_i(desc_i), .sel_i(sel_i), .hi_word_i(hi_word_i),
        .base_o(base_o), .limit_o(limit_o), .attr_o(attr_o),
        .upper_o(upper_o), .err_o(err_o)
    );

    function automatic logic [63:0] mk(input logic [31:0] b, input logic [19:0] lim,
                                       input logic [3:0] ty, input logic s,
                                       input logic [1:0] dpl, input logic p,
                                       input logic l, input logic d, input logic g);
        return {b[31:24], g, d, l, 1'b0, lim[19:16], p, dpl, s, ty, b[23:0], lim[15:0]};
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic chk_cache(input string req);
        chk(req, "base",  base_o,  e_base);
        chk(req, "limit", {32'd0, limit_o}, {32'd0, e_limit});
        chk(req, "attr",  {57'd0, attr_o},  {57'd0, e_attr});
    endtask

    task automatic strobe(input logic ld, input logic up, input logic [63:0] d,
                          input logic [15:0] s, input logic [31:0] hw);
        @(negedge clk);
        load_i = ld; upper_i = up; desc_i = d; sel_i = s; hi_word_i = hw;
        @(negedge clk);
        load_i = 1'b0; upper_i = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1", "base",  base_o, 64'd0);
        chk("R1", "limit", {32'd0, limit_o}, 64'd0);
        chk("R1", "attr",  {57'd0, attr_o}, 64'd0);
        chk("R1", "upper", upper_o, 64'd0);
        chk("R1", "err",   {63'd0, err_o}, 64'd0);
    endtask

    task automatic t_data_rw;   // R6 data read/write, R3 byte limit
        strobe(1, 0, mk(32'h12345678, 20'hABCDE, 4'h2, 1, 2'd3, 1, 0, 1, 0), 16'h0008, '0);
        e_base = 64'h12345678; e_limit = 32'h000ABCDE; e_attr = 7'h37;
        chk_cache("R6");
        chk("R3", "err", {63'd0, err_o}, 64'd0);
    endtask

    task automatic t_code_gran; // R5 code, R3 granular limit
        strobe(1, 0, mk(32'hFF000000, 20'h00012, 4'hA, 1, 2'd0, 1, 1, 0, 1), 16'h0013, '0);
        e_base = 64'hFF000000; e_limit = 32'h00012FFF; e_attr = 7'h18;
        chk_cache("R5");
    endtask

    task automatic t_data_expdown; // R6 expand-down read-only, R4 layout
        strobe(1, 0, mk(32'h00001000, 20'h00100, 4'h4, 1, 2'd1, 1, 0, 0, 0), 16'h0020, '0);
        e_base = 64'h00001000; e_limit = 32'h00000100; e_attr = 7'h51;
        chk_cache("R4");
    endtask

    task automatic t_null_sel; // R2
        strobe(1, 0, mk(32'hDEAD0000, 20'hFFFFF, 4'hA, 1, 2'd3, 1, 1, 1, 1), 16'h0003, '0);
        chk_cache("R2");
        chk("R2", "err", {63'd0, err_o}, 64'd0);
    endtask

    task automatic t_sys_plain; // R7 non-gate system
        strobe(1, 0, mk(32'h00400000, 20'h0FFFF, 4'h2, 0, 2'd0, 1, 0, 0, 0), 16'h0010, '0);
        e_base = 64'h00400000; e_limit = 32'h0000FFFF; e_attr = 7'h30;
        chk_cache("R7");
    endtask

    task automatic t_gate; // R7 gate rejected
        strobe(1, 0, mk(32'h11111111, 20'h22222, 4'hC, 0, 2'd2, 1, 0, 0, 0), 16'h0018, '0);
        chk("R7", "err", {63'd0, err_o}, 64'd1);
        chk_cache("R7");
    endtask

    task automatic t_not_present; // R8, R10 error holds
        strobe(1, 0, mk(32'h0BAD0000, 20'h00001, 4'h2, 1, 2'd0, 0, 0, 1, 0), 16'h0028, '0);
        chk("R8", "err", {63'd0, err_o}, 64'd1);
        chk_cache("R8");
        @(negedge clk);
        chk("R10", "err held", {63'd0, err_o}, 64'd1);
    endtask

    task automatic t_upper_tss; // R9 base layout, R11
        strobe(0, 1, mk(32'h12ABCDEF, 20'h00067, 4'h9, 0, 2'd0, 1, 0, 0, 0), 16'h0000, 32'hDEADBEEF);
        e_upper = 64'hDEADBEEF_12ABCDEF;
        chk("R9", "upper tss", upper_o, e_upper);
        chk("R9", "err", {63'd0, err_o}, 64'd0);
        chk_cache("R11");
    endtask

    task automatic t_upper_gate; // R9 offset layout
        strobe(0, 1, 64'h2222_8E00_0000_1111, 16'h0000, 32'h00000007);
        e_upper = 64'h00000007_22221111;
        chk("R9", "upper gate", upper_o, e_upper);
    endtask

    task automatic t_upper_bad; // R9 bad type
        strobe(0, 1, mk(32'h33333333, 20'h0, 4'h3, 0, 2'd0, 1, 0, 0, 0), 16'h0000, 32'hFFFFFFFF);
        chk("R9", "err", {63'd0, err_o}, 64'd1);
        chk("R9", "upper kept", upper_o, e_upper);
    endtask

    task automatic t_both; // R10 load priority
        strobe(1, 1, mk(32'h00ABC000, 20'h00FFF, 4'h3, 1, 2'd2, 1, 0, 1, 0), 16'h0030, 32'h55555555);
        e_base = 64'h00ABC000; e_limit = 32'h00000FFF; e_attr = 7'h36;
        chk_cache("R10");
        chk("R10", "upper dropped", upper_o, e_upper);
        chk("R10", "err cleared", {63'd0, err_o}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_data_rw();
        t_code_gran();
        t_data_expdown();
        t_null_sel();
        t_sys_plain();
        t_gate();
        t_not_present();
        t_upper_tss();
        t_upper_gate();
        t_upper_bad();
        t_both();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule